// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block observes the two I2C bus lines alongside the local controller's own drive intentions. It finds start and stop conditions and keeps a bus-busy indication. It decides whether the local transmitter has lost arbitration under any of four collision rules, and it holds the local master/slave role. It sits beside a bit-level shifter and a register file. Those neighbours supply the transmit-active state and the pending repeated-start and stop requests, and they read back sticky flags. Each flag has a one-cycle set pulse and a one-cycle clear strobe.

The SCL and SDA inputs each pass through a two-flop synchroniser. A condition detector compares the synchronised value with the value one cycle older. A start is SDA falling while SCL stays high. A stop is SDA rising while SCL stays high. SCL rising and falling edges are also extracted. All flags and pulses are registered, so each one follows the causing pin change by three clock edges.

The role is held by a three-state machine:
- `ROLE_SLAVE` goes to `ROLE_MASTER` (transition *claim*) when master-request is set, the bus is free and no arbitration loss is pending.
- `ROLE_MASTER` goes to `ROLE_RELEASE` (transition *withdraw*) when master-request drops, and goes back to `ROLE_SLAVE` (transition *lose*) on an arbitration loss.
- `ROLE_RELEASE` goes to `ROLE_SLAVE` (transition *finish*) on a stop condition, to `ROLE_SLAVE` (transition *lose*) on an arbitration loss, and back to `ROLE_MASTER` (transition *resume*) when master-request returns.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A start condition sets `start_seen` and pulses `start_set` when the block is master or `slave_idle` is 0.
- R2: While `slave_idle` is 1 and the block is not master, start and stop conditions leave `start_seen` and `stop_seen` at 0.
- R3: A stop condition sets `stop_seen` and pulses `stop_set` when the block is master or `slave_idle` is 0.
- R4: `bus_busy` is 0 after reset. It is set by a start condition and cleared by a stop condition or a `bus_timeout` pulse. A start wins over a timeout in the same cycle.
- R5: `arb_lost` is never set while `xmit_active` is 0.
- R6: Loss rule A. SCL rises while the local side releases SDA (`sda_drive_low` = 0), but synchronised SDA is 0.
- R7: Loss rule B. A start condition appears while the local side releases SDA and has no repeated start pending. `start_seen` is set in the same cycle as `arb_lost`.
- R8: Loss rule C. As master with `rstart_req` = 1, SCL falls while SDA is still high and the local side has not pulled SDA low.
- R9: Loss rule D. As master with `stop_req` = 1, SCL falls while SDA was still low, so no stop could be formed.
- R10: The role becomes master (`is_master` = 1) when `master_req` is 1, `bus_busy` is 0 and `arb_lost` is 0. This includes an idle slave whose pending request is granted after a stop frees the bus.
- R11: An arbitration loss clears `is_master` in the same cycle that `arb_lost` rises.
- R12: After `master_req` drops, `is_master` stays 1 until the next stop condition, then clears.
- R13: `clr_start`, `clr_stop` and `clr_arb` clear their flags one edge later. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_drive_low | input | 1 | Local side currently intends to pull SDA low |
| xmit_active | input | 1 | Local transmitter is active |
| rstart_req | input | 1 | Local repeated start pending |
| stop_req | input | 1 | Local stop pending |
| master_req | input | 1 | Configuration: request bus mastership |
| slave_idle | input | 1 | Local slave is ignoring the bus |
| bus_timeout | input | 1 | Pulse: bus inactivity timeout |
| clr_start | input | 1 | Clear strobe for start_seen |
| clr_stop | input | 1 | Clear strobe for stop_seen |
| clr_arb | input | 1 | Clear strobe for arb_lost |
| start_seen | output | 1 | Sticky start flag |
| stop_seen | output | 1 | Sticky stop flag |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| is_master | output | 1 | Local role is master |
| bus_busy | output | 1 | Bus is occupied |
| start_set | output | 1 | One-cycle pulse when start_seen is set |
| stop_set | output | 1 | One-cycle pulse when stop_seen is set |
| arb_set | output | 1 | One-cycle pulse when arb_lost is set |

## Verification
A corrupted busy bit shows up directly at `bus_busy`. It also shows up one edge later as a wrong `is_master`, because the role machine grants mastership from it. A role machine stuck in the wrong state shows as `is_master` disagreeing with the request and stop history. It also shows as start and stop flags being raised or suppressed wrongly for an idle slave, on the very next condition. A wrong loss decision appears three edges after the SCL or SDA change that caused it, as `arb_lost` and a dropped `is_master`.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {
        ROLE_SLAVE   = 2'd0,
        ROLE_MASTER  = 2'd1,
        ROLE_RELEASE = 2'd2
    } role_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda_now;
        logic sda_prev;
    } bus_ev_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] init,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{init[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond
    import i2cm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // SCL high across both samples qualifies an SDA edge as a condition
    always_comb begin
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.sda_now  = sda_s;
        ev.sda_prev = sda_p;
    end
endmodule

// File: rtl/i2cm_arb.sv
module i2cm_arb #(
    parameter int NRULE = 4
) (
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start,
    input  logic sda_now,
    input  logic sda_prev,
    input  logic xmit_active,
    input  logic sda_drive_low,
    input  logic rstart_req,
    input  logic stop_req,
    input  logic is_master,
    output logic hit
);
    logic [NRULE-1:0] rule;

    always_comb begin
        rule = '0;
        // A: released SDA (a 1 or repeated start) but line reads 0 at SCL rise
        rule[0] = scl_rise & ~sda_drive_low & ~sda_now;
        // B: sending a 1, another device forms a repeated start
        rule[1] = start & ~sda_drive_low & ~rstart_req;
        // C: repeated start pending, SCL dropped before local SDA pull-down
        rule[2] = is_master & rstart_req & scl_fall & sda_prev & ~sda_drive_low;
        // D: stop pending, SDA held low by another device through the high time
        rule[3] = is_master & stop_req & scl_fall & ~sda_prev;
        hit = xmit_active & (|rule);
    end
endmodule

// File: rtl/i2cm_role.sv
module i2cm_role
    import i2cm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  master_req,
    input  logic  bus_busy,
    input  logic  arb_flag,
    input  logic  arb_hit,
    input  logic  ev_stop,
    output role_e role,
    output logic  is_master
);
    role_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) role <= ROLE_SLAVE;
        else        role <= nxt;
    end

    always_comb begin
        nxt = role;
        unique case (role)
            ROLE_SLAVE:   if (master_req && !bus_busy && !arb_flag && !arb_hit) nxt = ROLE_MASTER;
            ROLE_MASTER:  if (arb_hit)          nxt = ROLE_SLAVE;
                          else if (!master_req) nxt = ROLE_RELEASE;
            ROLE_RELEASE: if (arb_hit || ev_stop) nxt = ROLE_SLAVE;
                          else if (master_req)  nxt = ROLE_MASTER;
            default:      nxt = ROLE_SLAVE;
        endcase
    end

    always_comb begin
        unique case (role)
            ROLE_MASTER, ROLE_RELEASE: is_master = 1'b1;
            default:                   is_master = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_drive_low,
    input  logic xmit_active,
    input  logic rstart_req,
    input  logic stop_req,
    input  logic master_req,
    input  logic slave_idle,
    input  logic bus_timeout,
    input  logic clr_start,
    input  logic clr_stop,
    input  logic clr_arb,
    output logic start_seen,
    output logic stop_seen,
    output logic arb_lost,
    output logic is_master,
    output logic bus_busy,
    output logic start_set,
    output logic stop_set,
    output logic arb_set
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] line_s;
    bus_ev_t          ev;
    logic             arb_hit;
    logic             eligible;
    role_e            role;

    i2cm_sync #(.WIDTH(NLINE), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({scl_in, sda_in}), .init({NLINE{1'b1}}), .q(line_s)
    );

    i2cm_cond u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_s(line_s[1]), .sda_s(line_s[0]), .ev(ev)
    );

    i2cm_arb u_arb (
        .scl_rise(ev.scl_rise), .scl_fall(ev.scl_fall), .start(ev.start),
        .sda_now(ev.sda_now), .sda_prev(ev.sda_prev),
        .xmit_active(xmit_active), .sda_drive_low(sda_drive_low),
        .rstart_req(rstart_req), .stop_req(stop_req),
        .is_master(is_master), .hit(arb_hit)
    );

    i2cm_role u_role (
        .clk(clk), .rst_n(rst_n),
        .master_req(master_req), .bus_busy(bus_busy), .arb_flag(arb_lost),
        .arb_hit(arb_hit), .ev_stop(ev.stop),
        .role(role), .is_master(is_master)
    );

    assign eligible = is_master | ~slave_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_busy   <= 1'b0;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            arb_lost   <= 1'b0;
            start_set  <= 1'b0;
            stop_set   <= 1'b0;
            arb_set    <= 1'b0;
        end else begin
            if (ev.start)                      bus_busy <= 1'b1;
            else if (ev.stop || bus_timeout)   bus_busy <= 1'b0;

            start_set <= ev.start & eligible;
            stop_set  <= ev.stop & eligible;
            arb_set   <= arb_hit;

            if (ev.start && eligible) start_seen <= 1'b1;
            else if (clr_start)       start_seen <= 1'b0;
            if (ev.stop && eligible)  stop_seen  <= 1'b1;
            else if (clr_stop)        stop_seen  <= 1'b0;
            if (arb_hit)              arb_lost   <= 1'b1;
            else if (clr_arb)         arb_lost   <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic xmit_active,
    input logic master_req,
    input logic slave_idle,
    input logic ev_start,
    input logic ev_stop,
    input logic bus_timeout,
    input logic start_set,
    input logic arb_set,
    input logic arb_lost,
    input logic is_master,
    input logic bus_busy
);
    // R5
    a_r5_arb_needs_xmit: assert property (@(posedge clk) disable iff (!rst_n)
        arb_set |-> $past(xmit_active));
    // R11
    a_r11_loss_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        arb_set |-> !is_master);
    // R2
    a_r2_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_set |-> $past(is_master || !slave_idle));
    // R4
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> bus_busy);
    // R4
    a_r4_free_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop || bus_timeout) && !ev_start |=> !bus_busy);
    // R10
    a_r10_claim_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_master) |-> $past(master_req) && !$past(bus_busy) && !$past(arb_lost));
endmodule

bind i2c_bus_monitor i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .xmit_active(xmit_active), .master_req(master_req),
    .slave_idle(slave_idle), .ev_start(ev.start), .ev_stop(ev.stop),
    .bus_timeout(bus_timeout), .start_set(start_set), .arb_set(arb_set),
    .arb_lost(arb_lost), .is_master(is_master), .bus_busy(bus_busy)
);

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, drv_low = 1'b0, xmit = 1'b0;
    logic rstart = 1'b0, stopq = 1'b0, mreq = 1'b0, idle = 1'b0, tmo = 1'b0;
    logic c_start = 1'b0, c_stop = 1'b0, c_arb = 1'b0;
    logic start_seen, stop_seen, arb_lost, is_master, bus_busy;
    logic start_set, stop_set, arb_set;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    i2c_bus_monitor dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .sda_drive_low(drv_low), .xmit_active(xmit), .rstart_req(rstart),
        .stop_req(stopq), .master_req(mreq), .slave_idle(idle),
        .bus_timeout(tmo), .clr_start(c_start), .clr_stop(c_stop), .clr_arb(c_arb),
        .start_seen(start_seen), .stop_seen(stop_seen), .arb_lost(arb_lost),
        .is_master(is_master), .bus_busy(bus_busy), .start_set(start_set),
        .stop_set(stop_set), .arb_set(arb_set)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #5;
    endtask

    task automatic clear_all();
        @(negedge clk); c_start = 1; c_stop = 1; c_arb = 1;
        @(negedge clk); c_start = 0; c_stop = 0; c_arb = 0;
        settle();
    endtask

    task automatic t_reset();
        check("R4 reset busy", bus_busy, 1'b0);
        check("R1 reset start_seen", start_seen, 1'b0);
        check("R3 reset stop_seen", stop_seen, 1'b0);
        check("R5 reset arb_lost", arb_lost, 1'b0);
        check("R10 reset master", is_master, 1'b0);
    endtask

    task automatic t_start_stop_active();
        sda = 0; settle();
        check("R1 start_seen", start_seen, 1'b1);
        check("R4 busy on start", bus_busy, 1'b1);
        sda = 1; settle();
        check("R3 stop_seen", stop_seen, 1'b1);
        check("R4 free on stop", bus_busy, 1'b0);
        clear_all();
        check("R13 start cleared", start_seen, 1'b0);
        check("R13 stop cleared", stop_seen, 1'b0);
    endtask

    task automatic t_idle_slave();
        idle = 1;
        sda = 0; settle();
        check("R2 idle start ignored", start_seen, 1'b0);
        check("R4 idle busy", bus_busy, 1'b1);
        sda = 1; settle();
        check("R2 idle stop ignored", stop_seen, 1'b0);
        sda = 0; settle();
        @(negedge clk); tmo = 1; @(negedge clk); tmo = 0; settle();
        check("R4 timeout frees bus", bus_busy, 1'b0);
        sda = 1; settle();
        idle = 0;
    endtask

    task automatic t_rule_a();
        mreq = 1; settle();
        check("R10 master on free bus", is_master, 1'b1);
        scl = 0; settle(); sda = 0; settle();
        scl = 1; settle();
        check("R5 no loss without xmit", arb_lost, 1'b0);
        scl = 0; settle(); xmit = 1;
        scl = 1; settle();
        check("R6 rule A loss", arb_lost, 1'b1);
        check("R11 master dropped", is_master, 1'b0);
        xmit = 0; clear_all();
        check("R13 arb cleared", arb_lost, 1'b0);
        check("R10 master regained", is_master, 1'b1);
    endtask

    task automatic t_rule_b();
        scl = 0; settle(); sda = 1; settle(); scl = 1; settle();
        xmit = 1; sda = 0; settle();
        check("R7 rule B loss", arb_lost, 1'b1);
        check("R7 start with loss", start_seen, 1'b1);
        xmit = 0; clear_all();
        check("R10 no claim while busy", is_master, 1'b0);
        sda = 1; settle();
        check("R10 claim after stop", is_master, 1'b1);
        clear_all();
    endtask

    task automatic t_rule_c();
        scl = 0; settle();
        rstart = 1; xmit = 1; scl = 1; settle();
        check("R8 no loss before fall", arb_lost, 1'b0);
        scl = 0; settle();
        check("R8 rule C loss", arb_lost, 1'b1);
        rstart = 0; xmit = 0; clear_all();
        check("R10 master after C", is_master, 1'b1);
    endtask

    task automatic t_rule_d();
        stopq = 1; xmit = 1; drv_low = 1; sda = 0; settle();
        scl = 1; settle();
        drv_low = 0; settle();
        check("R9 no loss while high", arb_lost, 1'b0);
        scl = 0; settle();
        check("R9 rule D loss", arb_lost, 1'b1);
        stopq = 0; xmit = 0; clear_all();
    endtask

    task automatic t_withdraw();
        mreq = 0; settle();
        check("R12 master held after drop", is_master, 1'b1);
        scl = 1; settle(); sda = 1; settle();
        check("R12 master cleared on stop", is_master, 1'b0);
        check("R3 stop at master", stop_seen, 1'b1);
        clear_all();
    endtask

    task automatic t_idle_claim();
        idle = 1; sda = 0; settle();
        mreq = 1; settle();
        check("R10 idle waits busy", is_master, 1'b0);
        sda = 1; settle();
        check("R10 idle claims on stop", is_master, 1'b1);
        check("R2 idle stop not flagged", stop_seen, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        settle();
        t_reset();
        t_start_stop_active();
        t_idle_slave();
        t_rule_a();
        t_rule_b();
        t_rule_c();
        t_rule_d();
        t_withdraw();
        t_idle_claim();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule